// File: doc/BRIEF.md
# Selective Load-Miss Replay Tracker

This block sits beside an out-of-order scheduler. For every issued instruction it keeps a small record of which still-unresolved loads the instruction depends on, directly or through a chain of producers. The record is a bit matrix. Each column stands for one load issue slot of the memory pipeline. Each row stands for one pipeline stage of distance from the point of issue. When an instruction issues, it inherits the union of its producers' records. A load also marks its own slot in the first row. Every cycle each record moves down one row, so that a bit follows its load toward the stage where hits and misses become known.

When the memory pipeline reports a miss, it names the slot or slots that missed. Every tracked instruction that holds a bit for a missing slot in its bottom row is killed in that same cycle. One cycle later the tracker asks the scheduler to replay it, and it forgets that instruction's record. Instructions that do not depend on the missing load are left alone, even when they issued inside the same window. A bit that moves past the bottom row is dropped, because the load behind it has resolved as a hit.

The scheduler chooses the tracker entry for each issuing instruction and names up to two producer entries. Loads also carry their issue slot.

Top module: `replay_tracker`

## Requirements
- R1: After reset, every entry's kill flag, replay flag and pending flag is 0. Bit i of each output vector belongs to entry i.
- R2: A load that issues into entry e with slot s in cycle c shows a pending flag for e in cycles c+1 through c+DEPTH_ROWS. It is killed if, in cycle c+DEPTH_ROWS, bit s of the miss mask is set. Miss mask bit s stands for load slot s.
- R3: A miss in a slot the instruction does not depend on does not kill it. Nor does a miss arriving in a cycle other than the one in which the dependence reaches the bottom row.
- R4: An instruction that names a producer entry inherits the producer's dependences. It is killed in the same cycle as the producer's load.
- R5: Dependence is transitive: a consumer of a consumer of a load is killed by that load's miss.
- R6: An instruction that shares no dependence with the missing load is not killed, even if it issued while that load was in flight.
- R7: A dependence resolves DEPTH_ROWS cycles after the load issued. After that the pending flag drops, and a later miss on the same slot kills nothing.
- R8: A killed entry raises its replay flag for exactly one cycle, in the cycle after the kill. Its pending flag is 0 from that cycle on.
- R9: An instruction that issues in the cycle in which one of its named producers is killed is not tracked. Instead it raises its replay flag in the next cycle, with its pending flag at 0.
- R10: An instruction whose two producers depend on loads in different slots is killed by whichever load's miss reaches the bottom row first. After that kill, a later miss of the other load does not kill it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_idx | input | IDX_W | Entry the issuing instruction occupies |
| iss_is_load | input | 1 | Issuing instruction is a load |
| iss_slot | input | SLOT_W | Load issue slot of the issuing load |
| src_a_en | input | 1 | First producer entry is named |
| src_a_idx | input | IDX_W | First producer entry |
| src_b_en | input | 1 | Second producer entry is named |
| src_b_idx | input | IDX_W | Second producer entry |
| miss_mask | input | LOAD_SLOTS | One bit per load slot that misses this cycle |
| kill_vec | output | NUM_ENTRIES | Entries killed this cycle |
| replay_vec | output | NUM_ENTRIES | Entries asking for replay this cycle |
| pending_vec | output | NUM_ENTRIES | Entries holding an unresolved load dependence |

## Verification
The bench builds the tracker with eight entries, two load slots and three rows. That is small enough that random producer choices often form chains two and three deep, and often put both slots' bits into the same record. The three-row window is short, so each directed sequence can place a miss exactly in the kill cycle, one cycle late, or in the wrong slot, and can also issue a consumer in the very cycle its producer dies.

// File: rtl/replay_tracker_pkg.sv
package replay_tracker_pkg;
   localparam int DEF_ENTRIES = 8;
   localparam int DEF_SLOTS   = 2;
   localparam int DEF_ROWS    = 3;

   typedef enum logic [1:0] {
      ACT_ADVANCE = 2'd0,
      ACT_FILL    = 2'd1,
      ACT_FLUSH   = 2'd2
   } entry_act_e;

   function automatic int safe_clog2(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/replay_src_merge.sv
module replay_src_merge
   import replay_tracker_pkg::*;
#(
   parameter int NUM_ENTRIES = DEF_ENTRIES,
   parameter int LOAD_SLOTS  = DEF_SLOTS,
   parameter int DEPTH_ROWS  = DEF_ROWS,
   localparam int MAT_W  = LOAD_SLOTS * DEPTH_ROWS,
   localparam int IDX_W  = safe_clog2(NUM_ENTRIES),
   localparam int SLOT_W = safe_clog2(LOAD_SLOTS),
   localparam int LAST_LO = (DEPTH_ROWS - 1) * LOAD_SLOTS
) (
   input  logic [NUM_ENTRIES*MAT_W-1:0] all_mats,
   input  logic                         is_load,
   input  logic [SLOT_W-1:0]            slot,
   input  logic                         a_en,
   input  logic [IDX_W-1:0]             a_idx,
   input  logic                         b_en,
   input  logic [IDX_W-1:0]             b_idx,
   input  logic [LOAD_SLOTS-1:0]        miss_mask,
   output logic [MAT_W-1:0]             child_mat,
   output logic                         src_killed
);
   logic [MAT_W-1:0]      mat_a;
   logic [MAT_W-1:0]      mat_b;
   logic [MAT_W-1:0]      merged;
   logic [LOAD_SLOTS-1:0] own_bits;
   logic                  a_ok;
   logic                  b_ok;

   assign a_ok = a_en && (32'(a_idx) < NUM_ENTRIES);
   assign b_ok = b_en && (32'(b_idx) < NUM_ENTRIES);

   always_comb begin
      mat_a = '0;
      mat_b = '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
         if (a_ok && (32'(a_idx) == e)) mat_a = all_mats[e*MAT_W +: MAT_W];
         if (b_ok && (32'(b_idx) == e)) mat_b = all_mats[e*MAT_W +: MAT_W];
      end
   end

   assign merged = mat_a | mat_b;

   genvar s;
   generate
      for (s = 0; s < LOAD_SLOTS; s++) begin : g_own
         assign own_bits[s] = is_load && (32'(slot) == s);
      end
   endgenerate

   generate
      if (DEPTH_ROWS > 1) begin : g_deep
         assign child_mat = {merged[LAST_LO-1:0], own_bits};
      end else begin : g_flat
         assign child_mat = own_bits;
      end
   endgenerate

   assign src_killed = |(merged[LAST_LO +: LOAD_SLOTS] & miss_mask);
endmodule

// File: rtl/replay_entry.sv
module replay_entry
   import replay_tracker_pkg::*;
#(
   parameter int LOAD_SLOTS = DEF_SLOTS,
   parameter int DEPTH_ROWS = DEF_ROWS,
   localparam int MAT_W   = LOAD_SLOTS * DEPTH_ROWS,
   localparam int LAST_LO = (DEPTH_ROWS - 1) * LOAD_SLOTS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fill_en,
   input  logic [MAT_W-1:0]      fill_mat,
   input  logic                  fill_doomed,
   input  logic [LOAD_SLOTS-1:0] miss_mask,
   output logic [MAT_W-1:0]      mat_q,
   output logic                  kill_o,
   output logic                  replay_o,
   output logic                  pending_o
);
   entry_act_e       act;
   logic [MAT_W-1:0] advanced;
   logic [MAT_W-1:0] mat_d;
   logic             replay_d;

   assign kill_o    = |(mat_q[LAST_LO +: LOAD_SLOTS] & miss_mask);
   assign pending_o = |mat_q;

   generate
      if (DEPTH_ROWS > 1) begin : g_shift
         assign advanced = {mat_q[LAST_LO-1:0], {LOAD_SLOTS{1'b0}}};
      end else begin : g_noshift
         assign advanced = '0;
      end
   endgenerate

   always_comb begin
      if (fill_en)     act = ACT_FILL;
      else if (kill_o) act = ACT_FLUSH;
      else             act = ACT_ADVANCE;
   end

   always_comb begin
      unique case (act)
         ACT_FILL:  mat_d = fill_doomed ? '0 : fill_mat;
         ACT_FLUSH: mat_d = '0;
         default:   mat_d = advanced;
      endcase
      replay_d = kill_o || (fill_en && fill_doomed);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mat_q    <= '0;
         replay_o <= 1'b0;
      end else begin
         mat_q    <= mat_d;
         replay_o <= replay_d;
      end
   end

   // R8: a kill is answered by a replay request one cycle later
   assert_replay_after_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      kill_o |=> replay_o);

   // R8: a killed record is forgotten unless overwritten
   assert_cleared_after_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_o && !fill_en) |=> (mat_q == '0));

   // R7: without a fill, a record only moves down, never gains bits
   assert_no_new_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_en |=> ((mat_q & ~MAT_W'($past(mat_q) << LOAD_SLOTS)) == '0));
endmodule

// File: rtl/replay_tracker.sv
module replay_tracker
   import replay_tracker_pkg::*;
#(
   parameter int NUM_ENTRIES = DEF_ENTRIES,
   parameter int LOAD_SLOTS  = DEF_SLOTS,
   parameter int DEPTH_ROWS  = DEF_ROWS,
   localparam int MAT_W  = LOAD_SLOTS * DEPTH_ROWS,
   localparam int IDX_W  = safe_clog2(NUM_ENTRIES),
   localparam int SLOT_W = safe_clog2(LOAD_SLOTS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   iss_valid,
   input  logic [IDX_W-1:0]       iss_idx,
   input  logic                   iss_is_load,
   input  logic [SLOT_W-1:0]      iss_slot,
   input  logic                   src_a_en,
   input  logic [IDX_W-1:0]       src_a_idx,
   input  logic                   src_b_en,
   input  logic [IDX_W-1:0]       src_b_idx,
   input  logic [LOAD_SLOTS-1:0]  miss_mask,
   output logic [NUM_ENTRIES-1:0] kill_vec,
   output logic [NUM_ENTRIES-1:0] replay_vec,
   output logic [NUM_ENTRIES-1:0] pending_vec
);
   logic [NUM_ENTRIES*MAT_W-1:0] all_mats;
   logic [MAT_W-1:0]             child_mat;
   logic                         src_killed;

   initial begin
      // R1: geometry must be sane for the reset state to be meaningful
      assert_params_R1: assert (NUM_ENTRIES >= 2 && LOAD_SLOTS >= 1 && DEPTH_ROWS >= 1);
   end

   replay_src_merge #(
      .NUM_ENTRIES(NUM_ENTRIES),
      .LOAD_SLOTS (LOAD_SLOTS),
      .DEPTH_ROWS (DEPTH_ROWS)
   ) u_merge (
      .all_mats  (all_mats),
      .is_load   (iss_is_load),
      .slot      (iss_slot),
      .a_en      (src_a_en),
      .a_idx     (src_a_idx),
      .b_en      (src_b_en),
      .b_idx     (src_b_idx),
      .miss_mask (miss_mask),
      .child_mat (child_mat),
      .src_killed(src_killed)
   );

   genvar e;
   generate
      for (e = 0; e < NUM_ENTRIES; e++) begin : g_entry
         logic hit;
         assign hit = iss_valid && (32'(iss_idx) == e);
         replay_entry #(
            .LOAD_SLOTS(LOAD_SLOTS),
            .DEPTH_ROWS(DEPTH_ROWS)
         ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .fill_en    (hit),
            .fill_mat   (child_mat),
            .fill_doomed(src_killed),
            .miss_mask  (miss_mask),
            .mat_q      (all_mats[e*MAT_W +: MAT_W]),
            .kill_o     (kill_vec[e]),
            .replay_o   (replay_vec[e]),
            .pending_o  (pending_vec[e])
         );
      end
   endgenerate

   // R8: a replay request always follows a reported miss
   assert_replay_needs_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|replay_vec) |-> $past(|miss_mask));

   // R2: a load that is not doomed is pending right after issue
   assert_load_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_is_load && !src_killed && (32'(iss_idx) < NUM_ENTRIES))
      |=> pending_vec[$past(iss_idx)]);

   // R9: issuing onto a dying producer yields an immediate replay
   assert_inherit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && src_killed && (32'(iss_idx) < NUM_ENTRIES))
      |=> (replay_vec[$past(iss_idx)] && !pending_vec[$past(iss_idx)]));
endmodule

// File: tb/replay_tracker_test.sv
`timescale 1ns/1ps
module replay_tracker_test;
   localparam int N = 8;
   localparam int S = 2;
   localparam int R = 3;
   localparam int W = S * R;
   localparam int IW = 3;
   localparam int SW = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          iss_valid = 1'b0;
   logic [IW-1:0] iss_idx = '0;
   logic          iss_is_load = 1'b0;
   logic [SW-1:0] iss_slot = '0;
   logic          src_a_en = 1'b0;
   logic [IW-1:0] src_a_idx = '0;
   logic          src_b_en = 1'b0;
   logic [IW-1:0] src_b_idx = '0;
   logic [S-1:0]  miss_mask = '0;
   logic [N-1:0]  kill_vec;
   logic [N-1:0]  replay_vec;
   logic [N-1:0]  pending_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [W-1:0] mm [N];
   logic [N-1:0] rp;

   always #10 clk = ~clk;

   replay_tracker #(.NUM_ENTRIES(N), .LOAD_SLOTS(S), .DEPTH_ROWS(R)) uut (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_idx(iss_idx),
      .iss_is_load(iss_is_load), .iss_slot(iss_slot), .src_a_en(src_a_en),
      .src_a_idx(src_a_idx), .src_b_en(src_b_en), .src_b_idx(src_b_idx),
      .miss_mask(miss_mask), .kill_vec(kill_vec), .replay_vec(replay_vec),
      .pending_vec(pending_vec));

   task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic logic last_hit(input logic [W-1:0] m, input logic [S-1:0] ms);
      return |(m[(R-1)*S +: S] & ms);
   endfunction

   task automatic step(input bit iv, input int idx, input bit ld, input int sl,
                       input bit ae, input int pa, input bit be, input int pb,
                       input logic [S-1:0] ms);
      logic [N-1:0] ek, ep;
      logic [W-1:0] nm, merged;
      logic         doomed;
      @(negedge clk);
      iss_valid = iv; iss_idx = IW'(idx); iss_is_load = ld; iss_slot = SW'(sl);
      src_a_en = ae; src_a_idx = IW'(pa); src_b_en = be; src_b_idx = IW'(pb);
      miss_mask = ms;
      #5;
      for (int i = 0; i < N; i++) begin
         ek[i] = last_hit(mm[i], ms);
         ep[i] = |mm[i];
      end
      chk("R4 kill", kill_vec, ek);
      chk("R8 replay", replay_vec, rp);
      chk("R7 pending", pending_vec, ep);
      merged = (ae ? mm[pa] : '0) | (be ? mm[pb] : '0);
      doomed = last_hit(merged, ms);
      nm = W'(merged << S);
      if (ld) nm[sl] = 1'b1;
      for (int i = 0; i < N; i++) begin
         rp[i] = ek[i] || (iv && idx == i && doomed);
         if (iv && idx == i)  mm[i] = doomed ? '0 : nm;
         else if (ek[i])      mm[i] = '0;
         else                 mm[i] = W'(mm[i] << S);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, '0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin : main
      for (int i = 0; i < N; i++) mm[i] = '0;
      rp = '0;
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #5;
      chk("R1 kill", kill_vec, '0);
      chk("R1 replay", replay_vec, '0);
      chk("R1 pending", pending_vec, '0);

      // load, independent load, child, then grandchild issued on a dying child
      step(1, 0, 1, 0, 0, 0, 0, 0, 2'b00);
      step(1, 5, 1, 1, 0, 0, 0, 0, 2'b00);
      step(1, 1, 0, 0, 1, 0, 0, 0, 2'b00);
      step(1, 2, 0, 0, 1, 1, 0, 0, 2'b01);
      chk("R4 kill load+child", kill_vec, 8'h03);
      chk("R6 independent spared", kill_vec & 8'h20, 8'h00);
      chk("R2 pending before miss", pending_vec, 8'h23);
      step(0, 0, 0, 0, 0, 0, 0, 0, 2'b01);
      chk("R8 replay set", replay_vec, 8'h07);
      chk("R9 doomed child not pending", pending_vec, 8'h20);
      chk("R3 late/wrong-slot miss", kill_vec, 8'h00);
      step(0, 0, 0, 0, 0, 0, 0, 0, 2'b10);
      chk("R7 resolved", pending_vec, 8'h00);
      chk("R7 miss after resolve", kill_vec, 8'h00);
      chk("R8 replay one cycle", replay_vec, 8'h00);
      idle(2);

      // three-level chain
      step(1, 0, 1, 0, 0, 0, 0, 0, 2'b00);
      step(1, 1, 0, 0, 1, 0, 0, 0, 2'b01);
      chk("R3 early miss", kill_vec, 8'h00);
      step(1, 2, 0, 0, 1, 1, 0, 0, 2'b00);
      chk("R5 chain pending", pending_vec, 8'h03);
      step(0, 0, 0, 0, 0, 0, 0, 0, 2'b01);
      chk("R5 chain killed", kill_vec, 8'h07);
      idle(3);

      // two producers in different slots
      step(1, 4, 1, 0, 0, 0, 0, 0, 2'b00);
      step(1, 6, 1, 1, 0, 0, 0, 0, 2'b00);
      step(1, 7, 0, 0, 1, 4, 1, 6, 2'b00);
      step(0, 0, 0, 0, 0, 0, 0, 0, 2'b01);
      chk("R10 first miss", kill_vec, 8'h90);
      step(0, 0, 0, 0, 0, 0, 0, 0, 2'b10);
      chk("R10 second miss", kill_vec, 8'h40);
      idle(3);

      // constrained random traffic
      for (int t = 0; t < 4000; t++) begin
         bit iv, ld, ae, be;
         int idx, sl, pa, pb;
         logic [S-1:0] ms;
         iv  = ($urandom % 4) != 0;
         idx = $urandom % N;
         ld  = ($urandom % 3) == 0;
         sl  = $urandom % S;
         ae  = ($urandom % 2) == 0;
         be  = ($urandom % 3) == 0;
         pa  = $urandom % N;
         pb  = $urandom % N;
         ms  = (($urandom % 4) == 0) ? S'($urandom % 3 + 1) : '0;
         if (last_hit(mm[idx], ms)) iv = 1'b0;
         step(iv, idx, ld, sl, ae, pa, be, pb, ms);
      end
      idle(4);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule